// File: doc/BRIEF.md
# SPI Flash Command Upload Capture

This block watches the serial command stream arriving at an emulated SPI flash and picks out the commands that must be handed to firmware instead of being served in hardware: whole-chip erase, sector erase and the three write-status commands. For each such command it builds a record with five fields: the opcode, whether an address followed, whether that address was four bytes long, the address value, and how many whole payload bytes came after the address. On the chip-select rising edge the record is committed and a pending flag is raised for firmware.

Firmware reads the record, then drops the flag with a one-cycle clear strobe. The address length of a sector erase follows the 3-byte or 4-byte address mode reported by the status tracker. That mode is sampled when the opcode byte completes. The SPI pins (mode 0: clock idle low, data sampled on the rising clock edge, most significant bit first) are expected already synchronised to `clk`. The block detects SPI clock edges by sampling.

Top module: `spi_upload_capture`

## Requirements
- R1: After reset `pending` is 0 and every record output is 0.
- R2: Opcode 0xC7 (chip erase) sent alone yields a record with opcode 0xC7, `recHasAddr`=0, `recAddr4b`=0, `recAddr`=0 and `recDataLen`=0.
- R3: Opcodes 0x01, 0x31 and 0x11 (write status) are each captured with no address. `recDataLen` holds the number of bytes that followed the opcode.
- R4: Opcode 0x20 (sector erase) in 3-byte mode (`addr4bMode`=0) takes the next 3 bytes as the address, most significant first. The record shows `recHasAddr`=1, `recAddr4b`=0 and the address zero-extended to 32 bits.
- R5: Opcode 0x20 in 4-byte mode (`addr4bMode`=1) takes the next 4 bytes as the address. The record shows `recHasAddr`=1 and `recAddr4b`=1.
- R6: The address mode is sampled when the opcode byte completes. A change of `addr4bMode` during the address bytes does not change the address length.
- R7: `recDataLen` counts only whole bytes after the address. Trailing bits of an unfinished byte are not counted.
- R8: `recDataLen` saturates at 2^LEN_W-1.
- R9: A record is committed, and `pending` rises, only on a chip-select rising edge. `pending` is 1 from the clock after the edge is sampled.
- R10: A sector erase whose chip select rises before the address is complete is discarded: the record and `pending` stay unchanged.
- R11: Any opcode other than the five listed is ignored and changes neither the record nor `pending`.
- R12: While `pending` is 1, a newly completed command does not overwrite the record.
- R13: `regClear` clears `pending`. If `regClear` falls in the same cycle as a commit, the new record is stored and `pending` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiCsN | input | 1 | Synchronised SPI chip select, active low |
| spiSclk | input | 1 | Synchronised SPI clock |
| spiMosi | input | 1 | Synchronised SPI data from host |
| addr4bMode | input | 1 | Current address mode from status tracker (1 = 4-byte) |
| regClear | input | 1 | Firmware strobe that clears the pending flag |
| pending | output | 1 | A record is waiting for firmware |
| recOpcode | output | 8 | Captured opcode |
| recHasAddr | output | 1 | Command carried an address |
| recAddr4b | output | 1 | Address was four bytes long |
| recAddr | output | 32 | Captured address |
| recDataLen | output | LEN_W | Whole payload bytes after the address, saturating |

## Verification
Two functions can fall in the same cycle: the commit on a chip-select rising edge and the firmware clear strobe. The bench lines them up on purpose. It raises chip select and pulses `regClear` on the same clock while an older record is still pending. It then expects the new command's fields in the record and `pending` still set. A clear issued with chip select idle must leave `pending` at 0. In the random phase the clears land at arbitrary points relative to commits, and each case is judged against a model of the record and the flag.

// File: rtl/upl_pkg.sv
package upl_pkg;
  localparam int ADDR_W = 32;
  localparam logic [7:0] OP_CHIP_ERASE = 8'hC7;
  localparam logic [7:0] OP_SECT_ERASE = 8'h20;
  localparam logic [7:0] OP_WRSR1 = 8'h01;
  localparam logic [7:0] OP_WRSR2 = 8'h31;
  localparam logic [7:0] OP_WRSR3 = 8'h11;

  typedef enum logic [2:0] {PH_IDLE, PH_OPC, PH_ADDR, PH_DATA, PH_SKIP} phase_e;

  typedef struct packed {
    logic shiftBit;
    logic txnStart;
    logic opLoad;
    logic addrLoad;
    logic dataInc;
    logic commit;
  } upl_strobe_t;

  function automatic logic isUpload(input logic [7:0] op);
    return op == OP_CHIP_ERASE || op == OP_SECT_ERASE ||
           op == OP_WRSR1 || op == OP_WRSR2 || op == OP_WRSR3;
  endfunction
endpackage

// File: rtl/upl_ctrl.sv
module upl_ctrl
  import upl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiCsN,
  input  logic        spiSclk,
  input  logic        addr4bMode,
  input  logic        regClear,
  input  logic        pendingQ,
  input  logic [7:0]  nextByte,
  output upl_strobe_t stb
);
  logic sclkQ, csQ;
  logic [2:0] bitCnt;
  logic [2:0] addrLeft;
  phase_e phase;

  logic sclkRise, csFall, csRise, byteDone;
  assign sclkRise = spiSclk & ~sclkQ & ~spiCsN;
  assign csFall   = csQ & ~spiCsN;
  assign csRise   = ~csQ & spiCsN;
  assign byteDone = sclkRise && (bitCnt == 3'd7);

  always_comb begin
    stb.shiftBit = sclkRise;
    stb.txnStart = csFall;
    stb.opLoad   = byteDone && phase == PH_OPC && isUpload(nextByte);
    stb.addrLoad = byteDone && phase == PH_ADDR;
    stb.dataInc  = byteDone && phase == PH_DATA;
    stb.commit   = csRise && phase == PH_DATA && (!pendingQ || regClear);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      csQ      <= 1'b1;
      bitCnt   <= '0;
      addrLeft <= '0;
      phase    <= PH_IDLE;
    end else begin
      sclkQ <= spiSclk;
      csQ   <= spiCsN;
      if (csFall) begin
        bitCnt <= '0;
        phase  <= PH_OPC;
      end else if (csRise) begin
        phase <= PH_IDLE;
      end else if (sclkRise) begin
        bitCnt <= bitCnt + 3'd1;
        if (byteDone) begin
          unique case (phase)
            PH_OPC: begin
              if (!isUpload(nextByte)) phase <= PH_SKIP;
              else if (nextByte == OP_SECT_ERASE) begin
                phase    <= PH_ADDR;
                addrLeft <= addr4bMode ? 3'd4 : 3'd3;
              end else phase <= PH_DATA;
            end
            PH_ADDR: begin
              addrLeft <= addrLeft - 3'd1;
              if (addrLeft == 3'd1) phase <= PH_DATA;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/upl_data.sv
module upl_data
  import upl_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiMosi,
  input  logic              addr4bMode,
  input  logic              regClear,
  input  upl_strobe_t       stb,
  output logic [7:0]        nextByte,
  output logic              pendingQ,
  output logic [7:0]        recOpcode,
  output logic              recHasAddr,
  output logic              recAddr4b,
  output logic [ADDR_W-1:0] recAddr,
  output logic [LEN_W-1:0]  recDataLen
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [7:0]        rxShift;
  logic [7:0]        wOpcode;
  logic              wHasAddr, wAddr4b;
  logic [ADDR_W-1:0] wAddr;
  logic [LEN_W-1:0]  wLen;

  assign nextByte = {rxShift[6:0], spiMosi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      wOpcode  <= '0;
      wHasAddr <= 1'b0;
      wAddr4b  <= 1'b0;
      wAddr    <= '0;
      wLen     <= '0;
    end else begin
      if (stb.shiftBit) rxShift <= nextByte;
      if (stb.txnStart) begin
        wOpcode  <= '0;
        wHasAddr <= 1'b0;
        wAddr4b  <= 1'b0;
        wAddr    <= '0;
        wLen     <= '0;
      end else begin
        if (stb.opLoad) begin
          wOpcode  <= nextByte;
          wHasAddr <= (nextByte == OP_SECT_ERASE);
          wAddr4b  <= (nextByte == OP_SECT_ERASE) && addr4bMode;
        end
        if (stb.addrLoad) wAddr <= {wAddr[ADDR_W-9:0], nextByte};
        if (stb.dataInc && wLen != LEN_MAX) wLen <= wLen + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ   <= 1'b0;
      recOpcode  <= '0;
      recHasAddr <= 1'b0;
      recAddr4b  <= 1'b0;
      recAddr    <= '0;
      recDataLen <= '0;
    end else if (stb.commit) begin
      pendingQ   <= 1'b1;
      recOpcode  <= wOpcode;
      recHasAddr <= wHasAddr;
      recAddr4b  <= wAddr4b;
      recAddr    <= wAddr;
      recDataLen <= wLen;
    end else if (regClear) begin
      pendingQ <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_upload_capture.sv
module spi_upload_capture
  import upl_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSclk,
  input  logic              spiMosi,
  input  logic              addr4bMode,
  input  logic              regClear,
  output logic              pending,
  output logic [7:0]        recOpcode,
  output logic              recHasAddr,
  output logic              recAddr4b,
  output logic [ADDR_W-1:0] recAddr,
  output logic [LEN_W-1:0]  recDataLen
);
  upl_strobe_t stb;
  logic [7:0]  nextByte;

  upl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .addr4bMode(addr4bMode), .regClear(regClear), .pendingQ(pending),
    .nextByte(nextByte), .stb(stb)
  );

  upl_data #(.LEN_W(LEN_W)) u_data (
    .clk(clk), .rstN(rstN), .spiMosi(spiMosi), .addr4bMode(addr4bMode),
    .regClear(regClear), .stb(stb), .nextByte(nextByte), .pendingQ(pending),
    .recOpcode(recOpcode), .recHasAddr(recHasAddr), .recAddr4b(recAddr4b),
    .recAddr(recAddr), .recDataLen(recDataLen)
  );
endmodule

// File: rtl/upl_capture_chk.sv
module upl_capture_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             spiCsN,
  input logic             regClear,
  input logic             pending,
  input logic [7:0]       recOpcode,
  input logic             recHasAddr,
  input logic             recAddr4b,
  input logic [31:0]      recAddr,
  input logic [LEN_W-1:0] recDataLen
);
  logic csD1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csD1 <= 1'b1;
    else csD1 <= spiCsN;
  end

  // R9
  commit_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(spiCsN && !csD1));

  // R12
  record_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending && !regClear |=> $stable(recOpcode) && $stable(recAddr) &&
      $stable(recDataLen) && $stable(recHasAddr) && $stable(recAddr4b));

  // R4
  addr_flag_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> recHasAddr == (recOpcode == 8'h20));

  // R2
  no_addr_fields_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending && !recHasAddr |-> !recAddr4b && recAddr == 32'd0);

  // R13
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    regClear && spiCsN && csD1 |=> !pending);
endmodule

bind spi_upload_capture upl_capture_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .regClear(regClear),
  .pending(pending), .recOpcode(recOpcode), .recHasAddr(recHasAddr),
  .recAddr4b(recAddr4b), .recAddr(recAddr), .recDataLen(recDataLen)
);

// File: tb/sim_spi_upload_capture.sv
module sim_spi_upload_capture;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic spiCsN = 1'b1, spiSclk = 1'b0, spiMosi = 1'b0;
  logic addr4bMode = 1'b0, regClear = 1'b0;
  logic pending, recHasAddr, recAddr4b;
  logic [7:0] recOpcode;
  logic [31:0] recAddr;
  logic [LEN_W-1:0] recDataLen;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [7:0] txBuf [0:299];

  logic mPend = 0, mHas = 0, m4b = 0;
  logic [7:0] mOp = 0;
  logic [31:0] mAddr = 0;
  logic [LEN_W-1:0] mLen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_upload_capture #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .addr4bMode(addr4bMode), .regClear(regClear),
    .pending(pending), .recOpcode(recOpcode), .recHasAddr(recHasAddr),
    .recAddr4b(recAddr4b), .recAddr(recAddr), .recDataLen(recDataLen)
  );

  function automatic logic benchIsUp(input logic [7:0] op);
    return op inside {8'hC7, 8'h20, 8'h01, 8'h31, 8'h11};
  endfunction

  function automatic logic [LEN_W-1:0] satLen(input int n);
    return (n > (1 << LEN_W) - 1) ? LEN_W'((1 << LEN_W) - 1) : LEN_W'(n);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkRecord(input string req);
    @(negedge clk);
    check(req, {13'd0, pending, recOpcode, recHasAddr, recAddr4b, recAddr, recDataLen},
               {13'd0, mPend, mOp, mHas, m4b, mAddr, mLen});
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); spiMosi = b; spiSclk = 1'b0;
    @(negedge clk);
    @(negedge clk); spiSclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic txn(input int nb, input int extraBits, input bit clrWith, input int flipAt);
    @(negedge clk); spiCsN = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      if (i == flipAt) addr4bMode = 1'b1;
      for (int k = 7; k >= 0; k--) sendBit(txBuf[i][k]);
    end
    for (int k = 0; k < extraBits; k++) sendBit(1'b1);
    @(negedge clk); spiSclk = 1'b0;
    @(negedge clk); spiCsN = 1'b1; regClear = clrWith;
    @(negedge clk); regClear = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseClear();
    @(negedge clk); regClear = 1'b1;
    @(negedge clk); regClear = 1'b0;
    mPend = 0;
  endtask

  task automatic modelCommit(input logic [7:0] op, input logic is4, input logic [31:0] a,
                             input int dlen, input bit clrWith);
    if (!mPend || clrWith) begin
      mPend = 1; mOp = op; mHas = (op == 8'h20); m4b = (op == 8'h20) && is4;
      mAddr = (op == 8'h20) ? (is4 ? a : {8'd0, a[23:0]}) : 32'd0;
      mLen = satLen(dlen);
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkRecord("R1 reset");

    // R2 chip erase alone
    txBuf[0] = 8'hC7; txn(1, 0, 0, -1); modelCommit(8'hC7, 0, 0, 0, 0);
    checkRecord("R2 chip erase");
    // R12 new command while pending is ignored
    txBuf[0] = 8'h01; txn(1, 0, 0, -1); modelCommit(8'h01, 0, 0, 0, 0);
    checkRecord("R12 no overwrite");
    pulseClear(); checkRecord("R13 clear");

    // R3 write-status opcodes
    foreach (txBuf[j]) if (j < 3) txBuf[j] = 8'h00;
    begin
      logic [7:0] ops [3] = '{8'h01, 8'h31, 8'h11};
      for (int i = 0; i < 3; i++) begin
        txBuf[0] = ops[i]; txBuf[1] = 8'hA5;
        txn(1 + i % 2, 0, 0, -1); modelCommit(ops[i], 0, 0, i % 2, 0);
        checkRecord("R3 write status"); pulseClear();
      end
    end

    // R4 sector erase 3-byte mode at 0x004000
    addr4bMode = 0;
    txBuf[0] = 8'h20; txBuf[1] = 8'h00; txBuf[2] = 8'h40; txBuf[3] = 8'h00;
    txn(4, 0, 0, -1); modelCommit(8'h20, 0, 32'h004000, 0, 0);
    checkRecord("R4 sector erase 3b"); pulseClear();

    // R5 sector erase 4-byte mode at 0x01004000
    addr4bMode = 1;
    txBuf[0] = 8'h20; txBuf[1] = 8'h01; txBuf[2] = 8'h00; txBuf[3] = 8'h40; txBuf[4] = 8'h00;
    txn(5, 0, 0, -1); modelCommit(8'h20, 1, 32'h01004000, 0, 0);
    checkRecord("R5 sector erase 4b"); pulseClear();

    // R6 mode flip after opcode: still 3 address bytes, 4th is data
    addr4bMode = 0;
    txBuf[1] = 8'h12; txBuf[2] = 8'h34; txBuf[3] = 8'h56; txBuf[4] = 8'h78;
    txn(5, 0, 0, 2); modelCommit(8'h20, 0, 32'h123456, 1, 0);
    checkRecord("R6 mode sampled at opcode"); pulseClear(); addr4bMode = 0;

    // R7 partial trailing bits not counted
    txBuf[0] = 8'hC7; txBuf[1] = 8'h11; txBuf[2] = 8'h22;
    txn(3, 5, 0, -1); modelCommit(8'hC7, 0, 0, 2, 0);
    checkRecord("R7 whole bytes only"); pulseClear();

    // R8 saturation
    for (int i = 1; i < 261; i++) txBuf[i] = 8'(i);
    txBuf[0] = 8'h31;
    txn(261, 0, 0, -1); modelCommit(8'h31, 0, 0, 260, 0);
    checkRecord("R8 length saturates"); pulseClear();

    // R10 aborted in address phase
    txBuf[0] = 8'h20; txBuf[1] = 8'hAB; txBuf[2] = 8'hCD;
    txn(3, 3, 0, -1);
    checkRecord("R10 abort discarded");

    // R11 unrelated opcode
    txBuf[0] = 8'h9F; txBuf[1] = 8'h00;
    txn(2, 0, 0, -1);
    checkRecord("R11 other opcode ignored");

    // R9 pending not raised before chip select rises
    txBuf[0] = 8'hC7;
    @(negedge clk); spiCsN = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 7; k >= 0; k--) sendBit(txBuf[0][k]);
    @(negedge clk); spiSclk = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 no commit while selected", {63'd0, pending}, 64'd0);
    spiCsN = 1'b1;
    @(negedge clk);
    check("R9 pending after rise", {63'd0, pending}, 64'd1);
    modelCommit(8'hC7, 0, 0, 0, 0);
    checkRecord("R9 record");

    // R13 clear in the same cycle as commit
    txBuf[0] = 8'h11; txBuf[1] = 8'h77;
    txn(2, 0, 1, -1); modelCommit(8'h11, 0, 0, 1, 1);
    checkRecord("R13 clear with commit"); pulseClear();

    // Random phase
    for (int it = 0; it < 40; it++) begin
      logic [7:0] rop;
      logic r4;
      logic [31:0] ra;
      int dl, nb, al;
      bit ab, cw;
      case ($urandom % 7)
        0: rop = 8'hC7; 1: rop = 8'h20; 2: rop = 8'h01; 3: rop = 8'h31;
        4: rop = 8'h11; 5: rop = 8'h9F; default: rop = 8'h06;
      endcase
      r4 = 1'($urandom % 2); ra = $urandom; dl = $urandom % 5;
      ab = (rop == 8'h20) && ($urandom % 4 == 0);
      cw = ($urandom % 4 == 0);
      addr4bMode = r4; al = 0;
      txBuf[0] = rop; nb = 1;
      if (rop == 8'h20) begin
        al = r4 ? 4 : 3;
        for (int b = 0; b < al; b++) txBuf[1 + b] = ra[8*(al-1-b) +: 8];
        nb = ab ? 1 + int'($urandom % al) : 1 + al;
      end
      if (!ab) for (int d = 0; d < dl; d++) begin txBuf[nb] = 8'($urandom); nb++; end
      txn(nb, ab ? 0 : int'($urandom % 8), cw, -1);
      if (benchIsUp(rop) && !ab) modelCommit(rop, r4, ra, dl, cw);
      else if (cw) mPend = 0;
      checkRecord("R12 R13 random");
      if ($urandom % 2 == 1) begin pulseClear(); checkRecord("R13 random clear"); end
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule